// File: doc/BRIEF.md
# Radix-5 Weight Quantizer

This block turns a block of signed 16-bit fixed-point weights into five-level integer codes in {-2, -1, 0, +1, +2}. It reads the same block twice. On the first pass it only watches the values and keeps the smallest and the largest. Between the passes it forms one fixed-point reciprocal of the spread between them. On the second pass it maps each weight linearly so that the smallest lands on -2 and the largest on +2, then rounds the result to an integer and emits the code.

A controller starts a run with a one-cycle `start` and a weight count. It streams the block in through a valid/ready input, then streams it in again, and drains the codes through a valid/ready output. A one-cycle `done` marks the end of the run. The radix, the data width, the count width and the fraction width of the scale are parameters. The code range is ±(RADIX−1)/2.

Top module: `rq5_quantizer`

## Requirements
- R1: Every emitted code is a 3-bit two's complement value in the set {-2, -1, 0, +1, +2}, that is one of 3'b110, 3'b111, 3'b000, 3'b001 or 3'b010.
- R2: When the largest and smallest weights of a block differ, every weight equal to the smallest yields -2 and every weight equal to the largest yields +2.
- R3: Let span = max − min. The scale is S = floor(4·2^24 / span). Each weight w gives D = (w − min)·S − 2·2^24, and its code is D / 2^24 rounded to the nearest integer.
- R4: When D / 2^24 falls exactly halfway between two integers, it rounds away from zero (+0.5 gives +1, −0.5 gives −1). The result is then limited to ±2.
- R5: When every weight in a block is equal, including a block of one weight, every code is 0.
- R6: No code is presented before the first pass has accepted `count` weights. The second pass yields exactly `count` codes, in input order.
- R7: While `out_valid` is high and `out_ready` is low, `out_code` and `out_valid` hold on the next cycle, and `in_ready` stays low.
- R8: `done` is high for exactly one cycle, on the cycle after the last code is accepted. A start with `count` = 0 produces `done` and no codes.
- R9: A `start` that arrives while a run is in progress is ignored, together with its `count`.
- R10: Outside a run, `in_ready` is low. After `done`, a new `start` begins a fresh block whose range does not depend on earlier blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that begins a run when idle |
| count | input | 16 | Number of weights in the block, sampled with start |
| in_valid | input | 1 | Weight on in_data is valid |
| in_ready | output | 1 | Block accepts the weight this cycle |
| in_data | input | 16 | Signed weight |
| out_valid | output | 1 | Code on out_code is valid |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | 3 | Signed five-level code |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest condition to reach from the ports is an exact rounding tie. It only happens when the reciprocal is exact and (w − min)·S lands on a half step. A directed block with a spread of 8 and weights 3 and 5 above the minimum produces ±0.5 exactly, which tests the away-from-zero rule. Random blocks of narrow, medium and full 16-bit spread are mixed in with random stalls on both handshakes. A stray start is injected partway through each run, and blocks of one weight, equal weights and zero count cover the degenerate ranges.

// File: rtl/rq5_pkg.sv
`timescale 1ns/1ps
package rq5_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_LOAD,
    ST_RECIP,
    ST_MAP,
    ST_DRAIN
  } qstate_e;
endpackage

// File: rtl/rq5_range_tracker.sv
`timescale 1ns/1ps
module rq5_range_tracker #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     sample_en,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] lo,
  output logic signed [DATA_W-1:0] hi,
  output logic        [DATA_W:0]   span
);
  logic empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo    <= '0;
      hi    <= '0;
      empty <= 1'b1;
    end else if (clear) begin
      empty <= 1'b1;
    end else if (sample_en) begin
      if (empty || sample < lo) lo <= sample;
      if (empty || sample > hi) hi <= sample;
      empty <= 1'b0;
    end
  end

  // Spread as an unsigned value one bit wider than the data
  always_comb begin
    span = $unsigned({hi[DATA_W-1], hi} - {lo[DATA_W-1], lo});
  end
endmodule

// File: rtl/rq5_recip_div.sv
`timescale 1ns/1ps
module rq5_recip_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             busy;
  logic [CW-1:0]    steps;
  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] nsh;
  logic [DEN_W:0]   trial;
  logic             ge;
  logic [DEN_W-1:0] rem_n;

  // One restoring step per cycle, most significant quotient bit first
  always_comb begin
    trial = {rem, nsh[NUM_W-1]};
    ge    = (trial >= {1'b0, den});
    rem_n = ge ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      steps <= '0;
      rem   <= '0;
      nsh   <= '0;
      quo   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        steps <= CW'(NUM_W);
        rem   <= '0;
        nsh   <= num;
        quo   <= '0;
      end else if (busy) begin
        rem   <= rem_n;
        quo   <= {quo[NUM_W-2:0], ge};
        nsh   <= nsh << 1;
        steps <= steps - CW'(1);
        if (steps == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rq5_code_map.sv
`timescale 1ns/1ps
module rq5_code_map #(
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 27,
  parameter int FRAC_W  = 24,
  parameter int HALF    = 2,
  parameter int CODE_W  = 3
) (
  input  logic signed [DATA_W-1:0]  w,
  input  logic signed [DATA_W-1:0]  lo,
  input  logic        [SCALE_W-1:0] scale,
  input  logic                      flat,
  output logic signed [CODE_W-1:0]  code
);
  localparam int OFF_W = DATA_W + 1;
  localparam int PW    = OFF_W + SCALE_W;
  localparam logic [PW:0] ONE_F   = (PW+1)'(1) << FRAC_W;
  localparam logic [PW:0] BIAS    = ONE_F * (PW+1)'(HALF);
  localparam logic [PW:0] ROUND_H = ONE_F >> 1;
  localparam logic [PW:0] HALF_W  = (PW+1)'(HALF);

  logic        [OFF_W-1:0]  offset;
  logic        [PW-1:0]     prod;
  logic signed [PW:0]       dev;
  logic        [PW:0]       mag;
  logic        [PW:0]       q;
  logic        [CODE_W-1:0] m;

  always_comb begin
    offset = $unsigned({w[DATA_W-1], w} - {lo[DATA_W-1], lo});
    prod   = PW'(offset) * PW'(scale);
    dev    = $signed({1'b0, prod}) - $signed(BIAS);
    mag    = dev[PW] ? $unsigned(-dev) : $unsigned(dev);
    q      = (mag + ROUND_H) >> FRAC_W;
    m      = (q > HALF_W) ? CODE_W'(HALF) : q[CODE_W-1:0];
    if (flat)         code = '0;
    else if (dev[PW]) code = $signed(-m);
    else              code = $signed(m);
  end
endmodule

// File: rtl/rq5_quantizer.sv
`timescale 1ns/1ps
module rq5_quantizer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int RADIX  = 5,
  parameter int FRAC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CNT_W-1:0]         count,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2((RADIX-1)/2+1):0] out_code,
  output logic                     done
);
  import rq5_pkg::*;

  localparam int HALF   = (RADIX - 1) / 2;
  localparam int CODE_W = $clog2(HALF + 1) + 1;
  localparam int SPAN_W = DATA_W + 1;
  localparam int NUM_W  = FRAC_W + $clog2(RADIX);
  localparam logic [NUM_W-1:0] NUMER = NUM_W'(RADIX - 1) << FRAC_W;

  qstate_e                     state;
  logic [CNT_W-1:0]            total;
  logic [CNT_W-1:0]            seen;
  logic [NUM_W-1:0]            scale;
  logic                        flat;
  logic                        div_go;
  logic                        div_fin;
  logic [NUM_W-1:0]            div_quo;
  logic signed [DATA_W-1:0]    lo;
  logic signed [DATA_W-1:0]    hi;
  logic [SPAN_W-1:0]           span;
  logic signed [CODE_W-1:0]    map_code;
  logic                        fire;
  logic                        last;
  logic                        trk_clr;
  logic                        trk_en;

  always_comb begin
    in_ready = (state == ST_SCAN) ||
               ((state == ST_MAP) && (!out_valid || out_ready));
    fire     = in_valid && in_ready;
    last     = (seen == total - CNT_W'(1));
    trk_clr  = (state == ST_IDLE) && start;
    trk_en   = (state == ST_SCAN) && fire;
  end

  rq5_range_tracker #(.DATA_W(DATA_W)) u_range (
    .clk       (clk),
    .rst       (rst),
    .clear     (trk_clr),
    .sample_en (trk_en),
    .sample    (in_data),
    .lo        (lo),
    .hi        (hi),
    .span      (span)
  );

  rq5_recip_div #(.NUM_W(NUM_W), .DEN_W(SPAN_W)) u_recip (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (NUMER),
    .den (span),
    .fin (div_fin),
    .quo (div_quo)
  );

  rq5_code_map #(
    .DATA_W  (DATA_W),
    .SCALE_W (NUM_W),
    .FRAC_W  (FRAC_W),
    .HALF    (HALF),
    .CODE_W  (CODE_W)
  ) u_map (
    .w     (in_data),
    .lo    (lo),
    .scale (scale),
    .flat  (flat),
    .code  (map_code)
  );

  // Run control: scan, reciprocal, map, drain
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      total  <= '0;
      seen   <= '0;
      scale  <= '0;
      flat   <= 1'b0;
      div_go <= 1'b0;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            total <= count;
            seen  <= '0;
            state <= (count == '0) ? ST_DRAIN : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (fire) begin
            if (last) begin
              seen  <= '0;
              state <= ST_LOAD;
            end else begin
              seen <= seen + CNT_W'(1);
            end
          end
        end
        ST_LOAD: begin
          if (span == '0) begin
            flat  <= 1'b1;
            state <= ST_MAP;
          end else begin
            flat   <= 1'b0;
            div_go <= 1'b1;
            state  <= ST_RECIP;
          end
        end
        ST_RECIP: begin
          if (div_fin) begin
            scale <= div_quo;
            state <= ST_MAP;
          end
        end
        ST_MAP: begin
          if (fire) begin
            if (last) state <= ST_DRAIN;
            else      seen  <= seen + CNT_W'(1);
          end
        end
        ST_DRAIN: begin
          if (!out_valid || out_ready) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if ((state == ST_MAP) && fire) begin
      out_valid <= 1'b1;
      out_code  <= map_code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rq5_quantizer_chk.sv
`timescale 1ns/1ps
module rq5_quantizer_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int RADIX  = 5,
  parameter int FRAC_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic [CNT_W-1:0]         count,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [$clog2((RADIX-1)/2+1):0] out_code,
  input logic                     done
);
  localparam int HALF = (RADIX - 1) / 2;

  logic             busy;
  logic [CNT_W:0]   need;
  logic [CNT_W:0]   taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      need  <= '0;
      taken <= '0;
    end else begin
      if (!busy && start) begin
        busy  <= 1'b1;
        need  <= {1'b0, count};
        taken <= '0;
      end else if (done) begin
        busy <= 1'b0;
      end else if (in_valid && in_ready) begin
        taken <= taken + (CNT_W+1)'(1);
      end
    end
  end

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_code) >= -HALF && $signed(out_code) <= HALF));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R7
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  early_out_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (taken < need)) |-> !out_valid);

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready);
endmodule

bind rq5_quantizer rq5_quantizer_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .RADIX  (RADIX),
  .FRAC_W (FRAC_W)
) u_chk (.*);

// File: tb/rq5_quantizer_tb.sv
`timescale 1ns/1ps
module rq5_quantizer_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [15:0]        count = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [2:0]         out_code;
  logic               done;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int wv [0:63];

  always #5 clk = ~clk;

  rq5_quantizer u_dut (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp = n_cmp + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected code from the R3/R4 formula
  function automatic int exp_code(int w, int mn, int mx);
    longint s, d, mag, q;
    if (mx == mn) return 0;
    s   = (64'sd4 <<< 24) / longint'(mx - mn);
    d   = longint'(w - mn) * s - (64'sd2 <<< 24);
    mag = (d < 0) ? -d : d;
    q   = (mag + (64'sd1 <<< 23)) >>> 24;
    if (q > 2) q = 2;
    return (d < 0) ? -int'(q) : int'(q);
  endfunction

  task automatic run_block(input int n, input string tag);
    int mn, mx, sent, got, pass, iter, code;
    bit sending, finished;
    mn = 32767; mx = -32768;
    for (int k = 0; k < n; k++) begin
      if (wv[k] < mn) mn = wv[k];
      if (wv[k] > mx) mx = wv[k];
    end
    sent = 0; got = 0; pass = 0; iter = 0;
    sending = (n > 0); finished = 0;
    @(negedge clk); start = 1'b1; count = 16'(n);
    @(posedge clk);
    while (!finished && iter < 20000) begin
      @(negedge clk);
      iter++;
      if (done) begin
        finished = 1;
        chk(got == n && !sending, "R8", got, n);      // done after last code
        chk(!in_ready, "R10", in_ready, 0);          // idle after run
      end else begin
        start     = (iter == 7 && n > 2);           // R9 stray start
        count     = (iter == 7) ? 16'd3 : 16'(n);
        in_valid  = sending && ($urandom % 4 != 0);
        in_data   = sending ? 16'(wv[sent]) : 16'sd0;
        out_ready = ($urandom % 4 != 0);
        #1;
        if (out_valid && out_ready) begin
          code = int'($signed(out_code));
          chk(pass == 1, "R6", pass, 1);
          if (got >= n) begin
            chk(0, "R6", got + 1, n);
          end else begin
            if (mx == mn)
              chk(code == 0, "R5", code, 0);
            else
              chk(code == exp_code(wv[got], mn, mx), tag, code, exp_code(wv[got], mn, mx));
            if (mx != mn && wv[got] == mn) chk(code == -2, "R2", code, -2);
            if (mx != mn && wv[got] == mx) chk(code == 2, "R2", code, 2);
            chk(code >= -2 && code <= 2, "R1", code, 0);
          end
          got++;
        end
        if (in_valid && in_ready) begin
          sent++;
          if (sent == n) begin
            if (pass == 0) begin pass = 1; sent = 0; end
            else sending = 0;
          end
        end
      end
    end
    if (!finished) chk(0, "R8", iter, 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    int n, base, spread, v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R10", in_ready, 0);
    chk(!out_valid, "R7", out_valid, 0);
    chk(!done, "R8", done, 0);

    // R4 ties: spread 8 gives exact +-0.5 at offsets 5 and 3
    wv[0] = 8; wv[1] = 3; wv[2] = 0; wv[3] = 5; wv[4] = 4;
    run_block(5, "R4");
    // R2 full 16-bit spread
    wv[0] = -32768; wv[1] = 32767; wv[2] = 0; wv[3] = -1; wv[4] = 16383; wv[5] = -16384;
    run_block(6, "R3");
    // R5 equal weights and a single weight
    for (int k = 0; k < 9; k++) wv[k] = -77;
    run_block(9, "R5");
    wv[0] = 1234;
    run_block(1, "R5");
    // R8 zero count
    run_block(0, "R8");
    // R3 random blocks of varied spread
    for (int b = 0; b < 9; b++) begin
      n = 1 + int'($urandom % 64);
      spread = (b % 3 == 0) ? 16 : ((b % 3 == 1) ? 2000 : 65535);
      base = int'($urandom % 65536) - 32768;
      for (int k = 0; k < n; k++) begin
        v = base + int'($urandom % 32'(spread)) - spread / 2;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        wv[k] = v;
      end
      run_block(n, "R3");
    end
    // R10 block after block: a narrow range directly after a wide one
    wv[0] = 10; wv[1] = 12; wv[2] = 11;
    run_block(3, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule